// File: doc/BRIEF.md
# Banked Host Window onto Video Memory

This block gives a host a 64 KB byte window into a 1 MB video memory. A segment register on the 3Cx I/O range holds two independent 4-bit bank numbers, one for reads and one for writes. When the display runs in any packed-pixel mode (8, 15, 16 or 24 bits per pixel), every host access inside the window is steered to video memory. The bank number for that direction selects which 64 KB slice is reached. When no packed-pixel mode is on, host accesses are handed unchanged to a separate planar access port.

Because the two bank numbers are independent, a host can copy between two slices of video memory by reading from one bank and writing to another, with no reprogramming between bytes. The video memory is a synchronous RAM: it registers read data one clock after the read strobe. The block therefore returns host read data with a one-cycle valid flag.

Top module: `bank_aperture`

## Requirements
- R1: After reset both bank numbers are 0: the segment register reads back 0x00, and banked accesses reach addresses 0x00000 to 0x0FFFF.
- R2: An I/O write at offset 0xD stores data bits 3:0 as the write bank and bits 7:4 as the read bank. I/O writes at any other offset leave both banks unchanged.
- R3: An I/O read at offset 0xD returns the read bank in bits 7:4 and the write bank in bits 3:0, in the same cycle. I/O reads at any other offset return 0x00.
- R4: Banked access is active whenever at least one of the four packed-pixel enables is set (bit 0 = 8 bpp, bit 1 = 15 bpp, bit 2 = 16 bpp, bit 3 = 24 bpp), in any combination.
- R5: A banked host write raises the video memory write strobe in the same cycle. The address is write bank × 0x10000 + offset, and the host data is passed through. If a host write and a host read are asserted in the same cycle, the write is performed and the read is dropped.
- R6: A banked host read raises the video memory read strobe in the same cycle, with address read bank × 0x10000 + offset.
- R7: Data for a banked read appears on the host read data one clock after the read strobe, with the valid flag high for exactly that one cycle.
- R8: With all packed-pixel enables clear, host reads and writes go to the planar port with the same offset and data. The video memory strobes stay low, and the planar port's returned data and valid flag are passed back to the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Offset within the 3Cx I/O range |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| mode_en | input | 4 | Packed-pixel enables: 8, 15, 16, 24 bpp |
| host_off | input | 16 | Host offset inside the 64 KB window |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_rvalid | output | 1 | Host read data valid |
| vram_addr | output | 20 | Video memory byte address |
| vram_wr | output | 1 | Video memory write strobe |
| vram_rd | output | 1 | Video memory read strobe |
| vram_wdata | output | 8 | Video memory write data |
| vram_rdata | input | 8 | Video memory read data (one clock after read) |
| planar_off | output | 16 | Offset forwarded to the planar port |
| planar_wr | output | 1 | Planar port write strobe |
| planar_rd | output | 1 | Planar port read strobe |
| planar_wdata | output | 8 | Data forwarded to the planar port |
| planar_rdata | input | 8 | Planar port read data |
| planar_rvalid | input | 1 | Planar port read data valid |

## Verification
Every one of the 256 pairs of read and write bank numbers is loaded and read back. Each pair is then used for one write and one read at offsets that change with the pair, including 0x0000 and 0xFFFF. This catches swapped nibbles, a shared bank, and carry or truncation faults at the slice edges. All sixteen combinations of the mode enables are applied with unequal read and write banks. This separates a single-mode decode from the any-mode rule and shows that the planar path is used only with every enable clear. Writes to the other fifteen I/O offsets, a combined read-and-write strobe, and the valid flag falling after one cycle cover the ignore and timing cases.

// File: rtl/bank_aperture_pkg.sv
package bank_aperture_pkg;

   // Bit positions of the packed-pixel enables on mode_en.
   typedef enum int unsigned {
      PX8_BIT  = 0,
      PX15_BIT = 1,
      PX16_BIT = 2,
      PX24_BIT = 3
   } px_bit_e;

   localparam int unsigned PX_MODE_COUNT = 4;

   // Which way a host access travels through the window.
   typedef enum logic [1:0] {
      ACC_NONE  = 2'b00,
      ACC_READ  = 2'b01,
      ACC_WRITE = 2'b10
   } acc_kind_e;

   function automatic acc_kind_e classify_access(input logic wr, input logic rd);
      if (wr)      return ACC_WRITE;
      else if (rd) return ACC_READ;
      else         return ACC_NONE;
   endfunction

endpackage

// File: rtl/bank_seg_reg.sv
module bank_seg_reg #(
   parameter int unsigned BANK_W    = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned IO_ADDR_W = 4,
   parameter logic [IO_ADDR_W-1:0] SEG_OFFSET = 'hD
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [IO_ADDR_W-1:0] io_addr,
   input  logic                 io_wr,
   input  logic                 io_rd,
   input  logic [DATA_W-1:0]    io_wdata,
   output logic [DATA_W-1:0]    io_rdata,
   output logic [BANK_W-1:0]    wr_bank,
   output logic [BANK_W-1:0]    rd_bank
);

   localparam int unsigned PACK_W = 2 * BANK_W;

   logic hit;
   logic [PACK_W-1:0] packed_q;

   assign hit = (io_addr == SEG_OFFSET);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_bank <= '0;
         rd_bank <= '0;
      end else if (io_wr && hit) begin
         wr_bank <= io_wdata[BANK_W-1:0];
         rd_bank <= io_wdata[PACK_W-1:BANK_W];
      end
   end

   assign packed_q = {rd_bank, wr_bank};

   generate
      if (DATA_W > PACK_W) begin : g_pad
         always_comb begin
            io_rdata = '0;
            if (io_rd && hit)
               io_rdata = {{(DATA_W-PACK_W){1'b0}}, packed_q};
         end
      end else begin : g_exact
         always_comb begin
            io_rdata = '0;
            if (io_rd && hit)
               io_rdata = packed_q;
         end
      end
   endgenerate

endmodule

// File: rtl/bank_addr_map.sv
module bank_addr_map #(
   parameter int unsigned OFF_W  = 16,
   parameter int unsigned BANK_W = 4
) (
   input  logic [BANK_W-1:0]       wr_bank,
   input  logic [BANK_W-1:0]       rd_bank,
   input  logic                    use_write,
   input  logic [OFF_W-1:0]        offset,
   output logic [OFF_W+BANK_W-1:0] addr
);

   localparam int unsigned VA_W = OFF_W + BANK_W;

   logic [BANK_W-1:0] sel_bank;

   // Bank times the window size plus the offset: the window size is a
   // power of two, so the product-and-sum is a plain concatenation.
   assign sel_bank = use_write ? wr_bank : rd_bank;

   always_comb begin
      addr = '0;
      addr[VA_W-1:OFF_W] = sel_bank;
      addr[OFF_W-1:0]    = offset;
   end

endmodule

// File: rtl/bank_route.sv
module bank_route
   import bank_aperture_pkg::*;
#(
   parameter int unsigned NUM_MODES = 4,
   parameter int unsigned OFF_W     = 16,
   parameter int unsigned DATA_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_MODES-1:0] mode_en,
   input  logic                 host_wr,
   input  logic                 host_rd,
   input  logic [OFF_W-1:0]     host_off,
   input  logic [DATA_W-1:0]    host_wdata,
   output logic [DATA_W-1:0]    host_rdata,
   output logic                 host_rvalid,
   output logic                 use_write,
   output logic                 vram_wr,
   output logic                 vram_rd,
   output logic [DATA_W-1:0]    vram_wdata,
   input  logic [DATA_W-1:0]    vram_rdata,
   output logic [OFF_W-1:0]     planar_off,
   output logic                 planar_wr,
   output logic                 planar_rd,
   output logic [DATA_W-1:0]    planar_wdata,
   input  logic [DATA_W-1:0]    planar_rdata,
   input  logic                 planar_rvalid
);

   logic [NUM_MODES-1:0] any_chain;
   logic banked;
   logic rd_pend_q;
   acc_kind_e kind;

   // OR-reduce the enables as a ripple so any count of modes is accepted.
   generate
      genvar gi;
      for (gi = 0; gi < NUM_MODES; gi++) begin : g_any
         if (gi == 0) begin : g_first
            assign any_chain[gi] = mode_en[gi];
         end else begin : g_next
            assign any_chain[gi] = any_chain[gi-1] | mode_en[gi];
         end
      end
   endgenerate

   assign banked = any_chain[NUM_MODES-1];
   assign kind   = classify_access(host_wr, host_rd);

   assign use_write  = (kind == ACC_WRITE);
   assign vram_wr    = banked && (kind == ACC_WRITE);
   assign vram_rd    = banked && (kind == ACC_READ);
   assign vram_wdata = host_wdata;

   assign planar_wr    = !banked && (kind == ACC_WRITE);
   assign planar_rd    = !banked && (kind == ACC_READ);
   assign planar_off   = host_off;
   assign planar_wdata = host_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) rd_pend_q <= 1'b0;
      else        rd_pend_q <= vram_rd;
   end

   assign host_rvalid = rd_pend_q | planar_rvalid;
   assign host_rdata  = rd_pend_q ? vram_rdata :
                        (planar_rvalid ? planar_rdata : '0);

endmodule

// File: rtl/bank_aperture.sv
module bank_aperture
   import bank_aperture_pkg::*;
#(
   parameter int unsigned OFF_W     = 16,
   parameter int unsigned BANK_W    = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned IO_ADDR_W = 4,
   parameter int unsigned NUM_MODES = PX_MODE_COUNT,
   parameter logic [IO_ADDR_W-1:0] SEG_OFFSET = 'hD
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [IO_ADDR_W-1:0]      io_addr,
   input  logic                      io_wr,
   input  logic                      io_rd,
   input  logic [DATA_W-1:0]         io_wdata,
   output logic [DATA_W-1:0]         io_rdata,
   input  logic [NUM_MODES-1:0]      mode_en,
   input  logic [OFF_W-1:0]          host_off,
   input  logic                      host_wr,
   input  logic                      host_rd,
   input  logic [DATA_W-1:0]         host_wdata,
   output logic [DATA_W-1:0]         host_rdata,
   output logic                      host_rvalid,
   output logic [OFF_W+BANK_W-1:0]   vram_addr,
   output logic                      vram_wr,
   output logic                      vram_rd,
   output logic [DATA_W-1:0]         vram_wdata,
   input  logic [DATA_W-1:0]         vram_rdata,
   output logic [OFF_W-1:0]          planar_off,
   output logic                      planar_wr,
   output logic                      planar_rd,
   output logic [DATA_W-1:0]         planar_wdata,
   input  logic [DATA_W-1:0]         planar_rdata,
   input  logic                      planar_rvalid
);

   localparam int unsigned VA_W = OFF_W + BANK_W;

   generate
      if (2 * BANK_W > DATA_W) begin : g_bad_pack
         $error("bank_aperture: two bank numbers must fit in one data byte");
      end
      if (OFF_W < 1 || BANK_W < 1) begin : g_bad_width
         $error("bank_aperture: offset and bank widths must be non-zero");
      end
      if (NUM_MODES < 1) begin : g_bad_modes
         $error("bank_aperture: at least one packed-pixel enable is needed");
      end
      if (VA_W > 32) begin : g_bad_va
         $error("bank_aperture: video address wider than 32 bits");
      end
   endgenerate

   logic [BANK_W-1:0] wr_bank;
   logic [BANK_W-1:0] rd_bank;
   logic              use_write;

   bank_seg_reg #(
      .BANK_W    (BANK_W),
      .DATA_W    (DATA_W),
      .IO_ADDR_W (IO_ADDR_W),
      .SEG_OFFSET(SEG_OFFSET)
   ) u_seg (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_addr (io_addr),
      .io_wr   (io_wr),
      .io_rd   (io_rd),
      .io_wdata(io_wdata),
      .io_rdata(io_rdata),
      .wr_bank (wr_bank),
      .rd_bank (rd_bank)
   );

   bank_addr_map #(
      .OFF_W (OFF_W),
      .BANK_W(BANK_W)
   ) u_map (
      .wr_bank  (wr_bank),
      .rd_bank  (rd_bank),
      .use_write(use_write),
      .offset   (host_off),
      .addr     (vram_addr)
   );

   bank_route #(
      .NUM_MODES(NUM_MODES),
      .OFF_W    (OFF_W),
      .DATA_W   (DATA_W)
   ) u_route (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_en      (mode_en),
      .host_wr      (host_wr),
      .host_rd      (host_rd),
      .host_off     (host_off),
      .host_wdata   (host_wdata),
      .host_rdata   (host_rdata),
      .host_rvalid  (host_rvalid),
      .use_write    (use_write),
      .vram_wr      (vram_wr),
      .vram_rd      (vram_rd),
      .vram_wdata   (vram_wdata),
      .vram_rdata   (vram_rdata),
      .planar_off   (planar_off),
      .planar_wr    (planar_wr),
      .planar_rd    (planar_rd),
      .planar_wdata (planar_wdata),
      .planar_rdata (planar_rdata),
      .planar_rvalid(planar_rvalid)
   );

endmodule

// File: rtl/bank_aperture_chk.sv
module bank_aperture_chk #(
   parameter int unsigned OFF_W     = 16,
   parameter int unsigned BANK_W    = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned IO_ADDR_W = 4,
   parameter int unsigned NUM_MODES = 4,
   parameter logic [IO_ADDR_W-1:0] SEG_OFFSET = 'hD
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [IO_ADDR_W-1:0]    io_addr,
   input logic                    io_wr,
   input logic                    io_rd,
   input logic [DATA_W-1:0]       io_wdata,
   input logic [DATA_W-1:0]       io_rdata,
   input logic [NUM_MODES-1:0]    mode_en,
   input logic [OFF_W-1:0]        host_off,
   input logic                    host_wr,
   input logic                    host_rd,
   input logic                    host_rvalid,
   input logic [OFF_W+BANK_W-1:0] vram_addr,
   input logic                    vram_wr,
   input logic                    vram_rd,
   input logic                    planar_wr,
   input logic                    planar_rd,
   input logic                    planar_rvalid,
   input logic [BANK_W-1:0]       wr_bank,
   input logic [BANK_W-1:0]       rd_bank
);

   localparam int unsigned VA_W = OFF_W + BANK_W;

   // R2: a segment write lands in both bank numbers on the next cycle.
   a_r2_seg_load: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == SEG_OFFSET) |=>
         (wr_bank == $past(io_wdata[BANK_W-1:0]) &&
          rd_bank == $past(io_wdata[2*BANK_W-1:BANK_W])));

   // R2: writes elsewhere leave the banks alone.
   a_r2_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && io_addr == SEG_OFFSET) |=> ($stable(wr_bank) && $stable(rd_bank)));

   // R3: readback packs the two numbers.
   a_r3_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && io_addr == SEG_OFFSET) |->
         (io_rdata[2*BANK_W-1:0] == {rd_bank, wr_bank}));

   // R4, R8: video memory is touched only with some mode enabled.
   a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_en == '0) |-> (!vram_wr && !vram_rd));

   // R8: with no mode enabled, host strobes reach the planar port.
   a_r8_planar: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_en == '0) |-> (planar_wr == host_wr && planar_rd == (host_rd && !host_wr)));

   // R5: write address uses the write bank and the host offset.
   a_r5_wr_addr: assert property (@(posedge clk) disable iff (!rst_n)
      vram_wr |-> (vram_addr[VA_W-1:OFF_W] == wr_bank && vram_addr[OFF_W-1:0] == host_off));

   // R6: read address uses the read bank.
   a_r6_rd_addr: assert property (@(posedge clk) disable iff (!rst_n)
      vram_rd |-> (vram_addr[VA_W-1:OFF_W] == rd_bank && vram_addr[OFF_W-1:0] == host_off));

   // R7: a banked read returns valid data one clock later.
   a_r7_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      vram_rd |=> host_rvalid);

   // R7: without a banked read the valid flag only mirrors the planar port.
   a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !vram_rd |=> (host_rvalid == planar_rvalid));

   // R5: never both memory strobes together.
   a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({vram_wr, vram_rd, planar_wr, planar_rd}));

endmodule

bind bank_aperture bank_aperture_chk #(
   .OFF_W     (OFF_W),
   .BANK_W    (BANK_W),
   .DATA_W    (DATA_W),
   .IO_ADDR_W (IO_ADDR_W),
   .NUM_MODES (NUM_MODES),
   .SEG_OFFSET(SEG_OFFSET)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .io_addr      (io_addr),
   .io_wr        (io_wr),
   .io_rd        (io_rd),
   .io_wdata     (io_wdata),
   .io_rdata     (io_rdata),
   .mode_en      (mode_en),
   .host_off     (host_off),
   .host_wr      (host_wr),
   .host_rd      (host_rd),
   .host_rvalid  (host_rvalid),
   .vram_addr    (vram_addr),
   .vram_wr      (vram_wr),
   .vram_rd      (vram_rd),
   .planar_wr    (planar_wr),
   .planar_rd    (planar_rd),
   .planar_rvalid(planar_rvalid),
   .wr_bank      (wr_bank),
   .rd_bank      (rd_bank)
);

// File: tb/bank_aperture_test.sv
`timescale 1ns/1ps
module bank_aperture_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [3:0]  mode_en = '0;
   logic [15:0] host_off = '0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        host_rvalid;
   logic [19:0] vram_addr;
   logic        vram_wr;
   logic        vram_rd;
   logic [7:0]  vram_wdata;
   logic [7:0]  vram_rdata = '0;
   logic [15:0] planar_off;
   logic        planar_wr;
   logic        planar_rd;
   logic [7:0]  planar_wdata;
   logic [7:0]  planar_rdata = '0;
   logic        planar_rvalid = 1'b0;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   bank_aperture uut (
      .clk(clk), .rst_n(rst_n),
      .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata),
      .mode_en(mode_en),
      .host_off(host_off), .host_wr(host_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
      .vram_addr(vram_addr), .vram_wr(vram_wr), .vram_rd(vram_rd),
      .vram_wdata(vram_wdata), .vram_rdata(vram_rdata),
      .planar_off(planar_off), .planar_wr(planar_wr), .planar_rd(planar_rd),
      .planar_wdata(planar_wdata), .planar_rdata(planar_rdata),
      .planar_rvalid(planar_rvalid)
   );

   // Data pattern a location "holds": computed from its address.
   function automatic logic [7:0] vram_pat(input logic [19:0] a);
      return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
   endfunction

   function automatic logic [7:0] planar_pat(input logic [15:0] o);
      return o[7:0] ^ o[15:8] ^ 8'hC3;
   endfunction

   // Synchronous memory and planar models.
   always @(posedge clk) begin
      if (vram_rd) vram_rdata <= vram_pat(vram_addr);
      planar_rvalid <= planar_rd;
      if (planar_rd) planar_rdata <= planar_pat(planar_off);
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic io_write(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic io_read_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1;
      chk(req, io_rdata, exp);
      io_rd = 1'b0;
   endtask

   task automatic host_write_chk(input logic [15:0] off, input logic [7:0] d,
                                 input bit banked, input logic [3:0] bank);
      @(negedge clk);
      host_off = off; host_wdata = d; host_wr = 1'b1;
      #1;
      if (banked) begin
         chk("R5 vram_wr", vram_wr, 1);
         chk("R5 addr", vram_addr, {bank, off});
         chk("R5 wdata", vram_wdata, d);
         chk("R4 planar_wr low", planar_wr, 0);
      end else begin
         chk("R8 vram_wr low", vram_wr, 0);
         chk("R8 planar_wr", planar_wr, 1);
         chk("R8 planar_off", planar_off, off);
         chk("R8 planar_wdata", planar_wdata, d);
      end
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read_chk(input logic [15:0] off, input bit banked, input logic [3:0] bank);
      @(negedge clk);
      host_off = off; host_rd = 1'b1;
      #1;
      if (banked) begin
         chk("R6 vram_rd", vram_rd, 1);
         chk("R6 addr", vram_addr, {bank, off});
         chk("R4 planar_rd low", planar_rd, 0);
      end else begin
         chk("R8 vram_rd low", vram_rd, 0);
         chk("R8 planar_rd", planar_rd, 1);
      end
      @(negedge clk);
      host_rd = 1'b0;
      chk("R7 rvalid", host_rvalid, 1);
      if (banked) chk("R7 rdata", host_rdata, vram_pat({bank, off}));
      else        chk("R8 rdata", host_rdata, planar_pat(off));
      @(negedge clk);
      chk("R7 rvalid one cycle", host_rvalid, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state.
      io_read_chk("R1 seg after reset", 4'hD, 8'h00);
      mode_en = 4'b0001;
      host_write_chk(16'hFFFF, 8'h11, 1, 4'h0);
      host_read_chk(16'h1234, 1, 4'h0);

      // R2, R3, R5, R6, R7: every pair of banks.
      for (int w = 0; w < 16; w++) begin
         for (int r = 0; r < 16; r++) begin
            logic [15:0] off;
            off = (r == 0) ? 16'h0000 : (w == 15 ? 16'hFFFF : 16'(w * 4099 + r * 257));
            mode_en = 4'(1 << ((w + r) % 4));
            io_write(4'hD, {4'(r), 4'(w)});
            io_read_chk("R3 seg readback", 4'hD, {4'(r), 4'(w)});
            host_write_chk(off, 8'(w * 16 + r), 1, 4'(w));
            host_read_chk(off ^ 16'h00F0, 1, 4'(r));
         end
      end

      // R4, R8: all enable combinations.
      io_write(4'hD, 8'h3A);
      for (int m = 0; m < 16; m++) begin
         mode_en = 4'(m);
         host_write_chk(16'(m * 4111), 8'(m + 7), m != 0, 4'hA);
         host_read_chk(16'(m * 3001 + 5), m != 0, 4'h3);
      end

      // R2, R3: other I/O offsets are ignored and read as zero.
      for (int a = 0; a < 16; a++) begin
         if (a != 13) begin
            io_write(4'(a), 8'hFF);
            io_read_chk("R2 seg unchanged", 4'hD, 8'h3A);
            io_read_chk("R3 other offset", 4'(a), 8'h00);
         end
      end

      // R5: read and write together -> write only.
      mode_en = 4'b1000;
      @(negedge clk);
      host_off = 16'h4321; host_wdata = 8'h9C; host_wr = 1'b1; host_rd = 1'b1;
      #1;
      chk("R5 both: vram_wr", vram_wr, 1);
      chk("R5 both: vram_rd", vram_rd, 0);
      chk("R5 both: addr", vram_addr, 20'hA4321);
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
      chk("R5 both: no rvalid", host_rvalid, 0);

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule